// File: doc/BRIEF.md
# Dual-Edge Burst Capture Buffer with Banked Storage

This block takes sample bursts from a fast converter and passes them to a slow 16-bit reader running on an unrelated clock. The converter supplies a data-ready clock and presents a new sample on each of its edges. Inside the block, the rising-edge sample and the falling-edge sample of each period are paired, so the write logic runs at the data-ready clock rate and stores two samples per cycle. The earlier sample of each pair goes to bank 0 and the later one to bank 1. Each sample holds `NUM_CH` channels of 14 bits.

The input rate is far higher than the readout rate, so the buffer works on whole blocks. A one-cycle arm pulse in the write domain starts a capture. The capture fills the buffer, then stops and raises a sticky done flag. The reader drains the buffer through a request/valid port. Each word holds one channel of one sample, and the words come out in original time order. A new capture can be armed only once the reader has emptied the buffer. Write and read pointers cross between the domains as Gray codes. Full is judged on the write side and empty on the read side.

Top module: `ddr_capture_fifo`

## Requirements
- R1: The first stored sample is the one present on the data-ready rising edge at which an accepted arm pulse is sampled high. Within each clock period, the rising-edge sample is stored before the falling-edge sample.
- R2: Samples are read out in strict time order, with the bank alternating 0, 1, 0, 1. Bank 0 holds the rising-edge samples and bank 1 holds the falling-edge samples.
- R3: Each output word carries one 14-bit channel value in bits [13:0], and bits [15:14] are zero. The channels of one sample come out as consecutive words, channel 0 first. Channel c occupies bits [14c+13:14c] of the sample input.
- R4: A capture stores exactly 2*BANK_DEPTH samples, and no sample is written after that. `full_o` is high while no pair slot is free, and it drops once the reader has freed a pair.
- R5: `done_o` rises after the buffer fills during a capture. It stays high until an arm pulse is accepted, and it is low in the cycle after that acceptance.
- R6: An arm pulse is ignored unless no capture is in progress and the write side sees the buffer empty. An ignored pulse writes nothing and leaves `done_o` unchanged.
- R7: A read request made while `empty_o` is low gives `rd_valid_o` with its word in the next read-clock cycle. With no request, `rd_valid_o` is low in the next cycle.
- R8: A read request made while `empty_o` is high returns no word and no valid strobe. It sets `underflow_o`, which stays high until the read-side reset.
- R9: `empty_o` is low while any stored word is unread, and high once the last word of a capture has been read.
- R10: After reset, `empty_o` is high, and `full_o`, `done_o`, `rd_valid_o` and `underflow_o` are low. A read-side reset clears `underflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk_i | input | 1 | Converter data-ready clock; samples arrive on both edges |
| wr_rst_ni | input | 1 | Active-low asynchronous reset, write domain |
| smp_i | input | NUM_CH*14 | Multi-channel sample bus, channel 0 in the low bits |
| arm_i | input | 1 | One-cycle capture start pulse, write domain |
| full_o | output | 1 | No free pair slot, write domain |
| done_o | output | 1 | Sticky capture-complete flag, write domain |
| rclk_i | input | 1 | Reader clock |
| rd_rst_ni | input | 1 | Active-low asynchronous reset, read domain |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | 16 | Output word, one channel of one sample |
| rd_valid_o | output | 1 | rd_data_o holds a word, one cycle after the request |
| empty_o | output | 1 | No unread word, read domain |
| underflow_o | output | 1 | Sticky flag set by a request made while empty |

## Verification
The bench builds the block with NUM_CH=2 and BANK_DEPTH=4. A capture is then 8 samples, or 16 words, so every word of every capture can be compared with a value computed from its sample index and channel. The 3-bit pair pointers wrap after two captures. Four back-to-back captures, armed at different phases, therefore take both Gray pointers through their wrap and check each output word across it. The small depth also lets the bench free exactly one pair mid-readout, which makes full fall while the buffer is still not empty. That is where an arm pulse must be ignored.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int SMP_W = 14;
  localparam int OUT_W = 16;

  function automatic logic [31:0] b2g(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] g2b(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_ddr_demux.sv
module dcf_ddr_demux #(
  parameter int DW = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] smp_i,
  output logic [DW-1:0] even_o,
  output logic [DW-1:0] odd_o
);
  logic [DW-1:0] rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= smp_i;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= smp_i;

  // sampled on the following rising edge: rise_q still holds the earlier sample
  assign even_o = rise_q;
  assign odd_o  = fall_q;
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end

  assign q_o = s2_q;
endmodule

// File: rtl/dcf_bank.sv
module dcf_bank #(
  parameter int AW = 2,
  parameter int DW = 28
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem[waddr_i] <= wdata_i;

  // read is combinational; the pointer handshake guarantees settled data
  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [AW:0]   rgray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic [AW:0]   wbin_o,
  output logic          full_o,
  output logic          done_o
);
  logic [AW:0] wbin_q, wgray_q, rbin_s, wbin_nx;
  logic        active_q, done_q, wempty, full;

  assign rbin_s  = (AW+1)'(g2b(32'(rgray_s_i)));
  assign full    = (wbin_q[AW] != rbin_s[AW]) && (wbin_q[AW-1:0] == rbin_s[AW-1:0]);
  assign wempty  = (wbin_q == rbin_s);
  assign wbin_nx = wbin_q + 1'b1;
  assign we_o    = active_q && !full;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wbin_q   <= '0;
      wgray_q  <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (we_o) begin
        wbin_q  <= wbin_nx;
        wgray_q <= (AW+1)'(b2g(32'(wbin_nx)));
      end
      if (arm_i && !active_q && wempty) begin
        active_q <= 1'b1;
        done_q   <= 1'b0;
      end else if (active_q && full) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign wbin_o  = wbin_q;
  assign full_o  = full;
  assign done_o  = done_q;
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int AW  = 2,
  parameter int NCH = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_en_i,
  input  logic [AW:0]          wgray_s_i,
  input  logic [NCH*SMP_W-1:0] b0_i,
  input  logic [NCH*SMP_W-1:0] b1_i,
  output logic [AW-1:0]        raddr_o,
  output logic [AW:0]          rgray_o,
  output logic [OUT_W-1:0]     rd_data_o,
  output logic                 rd_valid_o,
  output logic                 empty_o,
  output logic                 underflow_o
);
  localparam int DW = NCH * SMP_W;
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [AW:0]        rbin_q, rgray_q, wbin_s, rbin_nx;
  logic [CW-1:0]      ch_q;
  logic               bank_q, empty, fire, ch_last;
  logic [DW-1:0]      src;
  logic [SMP_W-1:0]   lane [NCH];
  logic [OUT_W-1:0]   data_q;
  logic               valid_q, uflow_q;

  assign wbin_s  = (AW+1)'(g2b(32'(wgray_s_i)));
  assign empty   = (rbin_q == wbin_s);
  assign fire    = rd_en_i && !empty;
  assign rbin_nx = rbin_q + 1'b1;
  assign ch_last = (ch_q == CW'(NCH - 1));
  assign src     = bank_q ? b1_i : b0_i;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane[g] = src[g*SMP_W +: SMP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      ch_q    <= '0;
      bank_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (rd_en_i && empty) uflow_q <= 1'b1;
      if (fire) begin
        data_q <= OUT_W'(lane[ch_q]);
        if (ch_last) begin
          ch_q <= '0;
          if (bank_q) begin
            bank_q  <= 1'b0;
            rbin_q  <= rbin_nx;
            rgray_q <= (AW+1)'(b2g(32'(rbin_nx)));
          end else begin
            bank_q <= 1'b1;
          end
        end else begin
          ch_q <= ch_q + 1'b1;
        end
      end
    end

  assign raddr_o     = rbin_q[AW-1:0];
  assign rgray_o     = rgray_q;
  assign rd_data_o   = data_q;
  assign rd_valid_o  = valid_q;
  assign empty_o     = empty;
  assign underflow_o = uflow_q;
endmodule

// File: rtl/ddr_capture_fifo.sv
module ddr_capture_fifo
  import dcf_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int BANK_DEPTH = 2048
) (
  input  logic                    dclk_i,
  input  logic                    wr_rst_ni,
  input  logic [NUM_CH*SMP_W-1:0] smp_i,
  input  logic                    arm_i,
  output logic                    full_o,
  output logic                    done_o,
  input  logic                    rclk_i,
  input  logic                    rd_rst_ni,
  input  logic                    rd_en_i,
  output logic [OUT_W-1:0]        rd_data_o,
  output logic                    rd_valid_o,
  output logic                    empty_o,
  output logic                    underflow_o
);
  localparam int AW = $clog2(BANK_DEPTH);
  localparam int DW = NUM_CH * SMP_W;

  logic [DW-1:0] wdat [2];
  logic [DW-1:0] rdat [2];
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   w_gray, w_bin, r_gray, w_gray_s, r_gray_s;

  dcf_ddr_demux #(.DW(DW)) u_demux (
    .clk_i (dclk_i),
    .rst_ni(wr_rst_ni),
    .smp_i (smp_i),
    .even_o(wdat[0]),
    .odd_o (wdat[1])
  );

  dcf_wr_ctrl #(.AW(AW)) u_wr (
    .clk_i    (dclk_i),
    .rst_ni   (wr_rst_ni),
    .arm_i    (arm_i),
    .rgray_s_i(r_gray_s),
    .we_o     (we),
    .waddr_o  (waddr),
    .wgray_o  (w_gray),
    .wbin_o   (w_bin),
    .full_o   (full_o),
    .done_o   (done_o)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    dcf_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk_i  (dclk_i),
      .we_i   (we),
      .waddr_i(waddr),
      .wdata_i(wdat[b]),
      .raddr_i(raddr),
      .rdata_o(rdat[b])
    );
  end

  dcf_sync #(.W(AW+1)) u_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rd_rst_ni),
    .d_i   (w_gray),
    .q_o   (w_gray_s)
  );

  dcf_sync #(.W(AW+1)) u_sync_r2w (
    .clk_i (dclk_i),
    .rst_ni(wr_rst_ni),
    .d_i   (r_gray),
    .q_o   (r_gray_s)
  );

  dcf_rd_ctrl #(.AW(AW), .NCH(NUM_CH)) u_rd (
    .clk_i      (rclk_i),
    .rst_ni     (rd_rst_ni),
    .rd_en_i    (rd_en_i),
    .wgray_s_i  (w_gray_s),
    .b0_i       (rdat[0]),
    .b1_i       (rdat[1]),
    .raddr_o    (raddr),
    .rgray_o    (r_gray),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .empty_o    (empty_o),
    .underflow_o(underflow_o)
  );
endmodule

// File: rtl/ddr_capture_fifo_chk.sv
module ddr_capture_fifo_chk #(
  parameter int AW = 2
) (
  input logic        dclk_i,
  input logic        wr_rst_ni,
  input logic        rclk_i,
  input logic        rd_rst_ni,
  input logic        arm_i,
  input logic        full_o,
  input logic        done_o,
  input logic        rd_en_i,
  input logic        rd_valid_o,
  input logic        empty_o,
  input logic        underflow_o,
  input logic [AW:0] w_gray,
  input logic [AW:0] w_bin
);
  p_wgray_step_r4: assert property (@(posedge dclk_i) disable iff (!wr_rst_ni)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  p_full_no_write_r4: assert property (@(posedge dclk_i) disable iff (!wr_rst_ni)
    full_o |=> $stable(w_bin));

  p_done_sticky_r5: assert property (@(posedge dclk_i) disable iff (!wr_rst_ni)
    (done_o && !arm_i) |=> done_o);

  p_valid_next_r7: assert property (@(posedge rclk_i) disable iff (!rd_rst_ni)
    (rd_en_i && !empty_o) |=> rd_valid_o);

  p_no_req_no_valid_r7: assert property (@(posedge rclk_i) disable iff (!rd_rst_ni)
    !rd_en_i |=> !rd_valid_o);

  p_empty_read_r8: assert property (@(posedge rclk_i) disable iff (!rd_rst_ni)
    (rd_en_i && empty_o) |=> (!rd_valid_o && underflow_o));

  p_uflow_sticky_r8: assert property (@(posedge rclk_i) disable iff (!rd_rst_ni)
    underflow_o |=> underflow_o);
endmodule

bind ddr_capture_fifo ddr_capture_fifo_chk #(.AW(AW)) u_chk (
  .dclk_i     (dclk_i),
  .wr_rst_ni  (wr_rst_ni),
  .rclk_i     (rclk_i),
  .rd_rst_ni  (rd_rst_ni),
  .arm_i      (arm_i),
  .full_o     (full_o),
  .done_o     (done_o),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .empty_o    (empty_o),
  .underflow_o(underflow_o),
  .w_gray     (w_gray),
  .w_bin      (w_bin)
);

// File: tb/tb_ddr_capture_fifo.sv
`timescale 1ns/100ps
module tb_ddr_capture_fifo;
  localparam int NCH   = 2;
  localparam int DEPTH = 4;
  localparam int SW    = 14;
  localparam int NWORD = 2 * DEPTH * NCH;

  logic            dclk, rclk, wr_rst_n, rd_rst_n, arm, rd_en;
  logic [NCH*SW-1:0] smp;
  logic            full, done, rd_valid, empty, uflow;
  logic [15:0]     rd_data;

  int checks = 0, fails = 0;
  int sidx = 0;
  int wd = 0;

  ddr_capture_fifo #(.NUM_CH(NCH), .BANK_DEPTH(DEPTH)) dut (
    .dclk_i(dclk), .wr_rst_ni(wr_rst_n), .smp_i(smp), .arm_i(arm),
    .full_o(full), .done_o(done),
    .rclk_i(rclk), .rd_rst_ni(rd_rst_n), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .empty_o(empty), .underflow_o(uflow)
  );

  initial dclk = 0;
  always #5 dclk = ~dclk;
  initial rclk = 0;
  always #18.5 rclk = ~rclk;

  function automatic logic [SW-1:0] sval(int i, int c);
    return SW'(i * 37 + c * 1111 + 5);
  endfunction

  function automatic logic [NCH*SW-1:0] spack(int i);
    logic [NCH*SW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*SW +: SW] = sval(i, c);
    return v;
  endfunction

  // new sample presented mid-way between edges; smp at an edge is sample sidx
  initial smp = spack(0);
  always @(dclk) begin
    #2.5;
    sidx = sidx + 1;
    smp  = spack(sidx);
  end

  always @(posedge dclk) begin
    wd = wd + 1;
    if (wd > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic arm_pulse(output int idx);
    @(negedge dclk); #1 arm = 1;
    @(posedge dclk); idx = sidx;
    @(negedge dclk); #1 arm = 0;
  endtask

  // reads count words, checking word numbers start..start+count-1 of capture s0
  task automatic read_words(int s0, int start, int count);
    int issued = 0, got = 0, guard = 0;
    bit pend = 0;
    while (got < count && guard < 2000) begin
      @(negedge rclk);
      guard++;
      if (pend) begin
        int w = start + got;
        chk("R7 valid after request", 32'(rd_valid), 1);
        chk("R1 R2 R3 word order/format", 32'(rd_data),
            32'({2'b00, sval(s0 + w / NCH, w % NCH)}));
        got++;
      end
      if (issued < count && !empty) begin
        rd_en = 1; pend = 1; issued++;
      end else begin
        rd_en = 0; pend = 0;
      end
    end
    rd_en = 0;
    @(negedge rclk);
    chk("R7 no valid without request", 32'(rd_valid), 0);
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 500) begin @(negedge dclk); t++; end
  endtask

  initial begin
    int s0, sdummy;
    arm = 0; rd_en = 0; wr_rst_n = 0; rd_rst_n = 0;
    #40;
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge rclk);
    chk("R10 empty after reset", 32'(empty), 1);
    chk("R10 full after reset", 32'(full), 0);
    chk("R10 done after reset", 32'(done), 0);
    chk("R10 valid after reset", 32'(rd_valid), 0);
    chk("R10 underflow after reset", 32'(uflow), 0);

    // read on empty
    rd_en = 1;
    @(negedge rclk); rd_en = 0;
    chk("R8 no valid on empty read", 32'(rd_valid), 0);
    chk("R8 underflow set", 32'(uflow), 1);
    @(negedge rclk);
    chk("R8 underflow sticky", 32'(uflow), 1);
    chk("R9 still empty", 32'(empty), 1);
    rd_rst_n = 0; @(negedge rclk); rd_rst_n = 1; @(negedge rclk);
    chk("R10 read reset clears underflow", 32'(uflow), 0);

    for (int r = 0; r < 4; r++) begin
      repeat (r * 3 + 1) @(negedge dclk);
      arm_pulse(s0);
      chk("R5 done low after accepted arm", 32'(done), 0);
      wait_done();
      chk("R5 done set on fill", 32'(done), 1);
      chk("R4 full after capture", 32'(full), 1);
      repeat (12) @(negedge dclk);
      chk("R5 done stays high", 32'(done), 1);
      @(negedge rclk);
      chk("R9 not empty with data", 32'(empty), 0);
      if (r == 1) begin
        read_words(s0, 0, 2 * NCH + 1);
        repeat (12) @(negedge dclk);
        chk("R4 full drops after pair freed", 32'(full), 0);
        arm_pulse(sdummy);
        repeat (12) @(negedge dclk);
        chk("R6 ignored arm keeps done", 32'(done), 1);
        chk("R6 ignored arm keeps full low", 32'(full), 0);
        read_words(s0, 2 * NCH + 1, NWORD - 2 * NCH - 1);
      end else begin
        read_words(s0, 0, NWORD);
      end
      chk("R4 R9 empty after exactly one capture", 32'(empty), 1);
      repeat (12) @(negedge dclk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule